// File: doc/BRIEF.md
# Bus Master Cycle Sequencer with Programmable Wait States

This block runs single read or write memory cycles on an external bus for one internal requester. A request is taken over a valid/ready handshake. The block then walks through one T1 bus state and one or more T2 bus states. It drives a cycle-start strobe, an address strobe and a data strobe, all active-low, together with address, status, direction and write data. On a read it captures the returned data and hands it back with a one-clock done pulse.

The block runs on a clock at twice the bus-state rate, so every bus state has a first half and a second half of one clock each. A two-bit configuration field adds zero to three programmed wait states between T1 and the final T2. An active-low acknowledge input can stretch the cycle further by repeating T2. In synchronous mode the acknowledge input is used as it arrives. In asynchronous mode it first goes through a two-flop synchronizer, and it may already be presented during the last programmed wait. The wait count and the mode are captured when a request is accepted.

Top module: `bus_master_seq`

## Requirements
- R1: During reset and while idle, the block holds req_ready=1 and done=0, all three strobes high, and bus_wdata_oe=0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. At the next clock cyc_start_n is low and req_ready is 0. req_ready stays 0 until the clock after done.
- R3: cyc_start_n is low for exactly one clock, the first half of T1. bus_addr, bus_stat, bus_write (1 = write) and bus_wdata take the request values from that clock on and stay constant through the done clock.
- R4: addr_stb_n is low from the second half of T1 through the first half of the final T2. That is 2+2W+2J clocks, where W is the wait count and J is the number of T2 states added by a late acknowledge.
- R5: cfg_waits = W (0 to 3) inserts W wait states. done is high exactly 3+2W+2J clocks after the clock in which cyc_start_n is low.
- R6: In synchronous mode ack_n is ignored during programmed waits. It is sampled at the end of the first half of each later T2, and T2 repeats until that sample is low.
- R7: In asynchronous mode ack_n passes through two flops before use. If it is seen low by the end of the last programmed wait, the first T2 after the waits is final.
- R8: On a read, data_stb_n is low over the same clocks as addr_stb_n.
- R9: On a write, data_stb_n goes low in the second half of the first T2 (wait or final) only if that T2 is not the final one. It stays low through the first half of the final T2. It is never low when the cycle has a single T2.
- R10: On a read, bus_rdata is captured at the middle of the final T2 and shown on done_rdata in the one clock that done is high.
- R11: On a write, bus_wdata_oe is high from the cyc_start_n clock through the done clock inclusive. On a read it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus-state rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_waits | input | 2 | Programmed wait count, 0 to 3 |
| cfg_async | input | 1 | 1 = asynchronous acknowledge mode |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, able to accept |
| req_addr | input | AW | Request address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_stat | input | SW | Request bus status code |
| req_wdata | input | DW | Request write data |
| done | output | 1 | One-clock completion pulse |
| done_rdata | output | DW | Read data captured on the last read |
| cyc_start_n | output | 1 | Cycle-start strobe, active low |
| addr_stb_n | output | 1 | Address strobe, active low |
| data_stb_n | output | 1 | Data strobe, active low |
| bus_addr | output | AW | Bus address |
| bus_stat | output | SW | Bus status code |
| bus_write | output | 1 | Direction, 1 = write |
| bus_wdata | output | DW | Write data |
| bus_wdata_oe | output | 1 | Write data output enable |
| bus_rdata | input | DW | Read data from the bus |
| ack_n | input | 1 | Cycle acknowledge, active low |

## Verification
A wrong phase, half or wait count shows at the ports as a strobe width or a done time that is off by a whole number of clocks. These errors are visible in the same cycle as the misplaced edge. Every transfer is therefore measured, and each strobe's low-clock count and the time to done are compared against values computed from W, the mode and the acknowledge delay. A wrong final-T2 decision moves done by two clocks and changes the strobe counts. A stray early acceptance of acknowledge during waits shortens the cycle. The write data strobe shows up as a non-zero count on single-T2 writes.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_T1, PH_TW, PH_T2} phase_e;

  typedef struct packed {
    phase_e ph;
    logic   hf;   // 0 = first half, 1 = second half
    logic   fin;  // final T2 (meaningful in T2 second half)
  } slot_t;
endpackage

// File: rtl/bmc_ack_cond.sv
module bmc_ack_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n,
  output logic ack_sync
);
  logic [STAGES-1:0] sh_q, sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = ack_n;
    end else begin : g_chain
      always_comb sh_d = {sh_q[STAGES-2:0], ack_n};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign ack_sync = ~sh_q[STAGES-1];
endmodule

// File: rtl/bmc_seq.sv
module bmc_seq
  import bmc_pkg::*;
#(
  parameter int WCW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [WCW-1:0] cfg_waits,
  input  logic           cfg_async,
  input  logic           ack_raw_n,
  input  logic           ack_sync,
  output slot_t          nxt
);
  slot_t          cur;
  logic [WCW-1:0] wcnt_q, wcnt_d, wlim_q, wlim_d;
  logic           async_q, async_d, early_q, early_d;
  logic           ack_ok;

  assign ack_ok = async_q ? ack_sync : ~ack_raw_n;

  always_comb begin
    nxt     = cur;
    wcnt_d  = wcnt_q;
    wlim_d  = wlim_q;
    async_d = async_q;
    early_d = early_q;
    nxt.fin = 1'b0;
    unique case (cur.ph)
      PH_IDLE: if (start) begin
        nxt.ph  = PH_T1;
        nxt.hf  = 1'b0;
        wlim_d  = cfg_waits;
        async_d = cfg_async;
        early_d = 1'b0;
      end
      PH_T1: begin
        nxt.hf = ~cur.hf;
        if (cur.hf) begin
          nxt.ph = (wlim_q != '0) ? PH_TW : PH_T2;
          wcnt_d = '0;
        end
      end
      PH_TW: begin
        nxt.hf = ~cur.hf;
        if (cur.hf) begin
          if (wcnt_q == wlim_q - 1'b1) begin
            nxt.ph  = PH_T2;
            early_d = async_q & ack_sync;   // acceptance in last wait
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
      end
      PH_T2: begin
        nxt.hf = ~cur.hf;
        if (!cur.hf) nxt.fin = ack_ok | early_q;
        else if (cur.fin) begin
          nxt.ph  = PH_IDLE;
          nxt.hf  = 1'b0;
          early_d = 1'b0;
        end
      end
      default: nxt.ph = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur     <= '{ph: PH_IDLE, hf: 1'b0, fin: 1'b0};
      wcnt_q  <= '0;
      wlim_q  <= '0;
      async_q <= 1'b0;
      early_q <= 1'b0;
    end else begin
      cur     <= nxt;
      wcnt_q  <= wcnt_d;
      wlim_q  <= wlim_d;
      async_q <= async_d;
      early_q <= early_d;
    end
  end

  // R5: the wait counter never runs past the captured limit
  assert_wait_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.ph == PH_TW) |-> (wcnt_q < wlim_q));

  // R6: a synchronous final T2 was preceded by a low acknowledge sample
  assert_sync_ack_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.ph == PH_T2 && cur.hf && cur.fin && !async_q && !early_q) |-> $past(!ack_raw_n));

  // R6: programmed waits always lead into T2, never straight to idle
  assert_wait_to_t2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.ph == PH_TW) |=> (cur.ph == PH_TW || cur.ph == PH_T2));
endmodule

// File: rtl/bmc_out.sv
module bmc_out
  import bmc_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  slot_t         nxt,
  input  logic          start,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wr,
  input  logic [SW-1:0] req_stat,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] done_rdata,
  output logic          cyc_start_n,
  output logic          addr_stb_n,
  output logic          data_stb_n,
  output logic [AW-1:0] bus_addr,
  output logic [SW-1:0] bus_stat,
  output logic          bus_write,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wdata_oe
);
  logic wr_eff, in_t2, last_h1, hold_as, cs_d, as_d, ds_d, oe_d, done_d, ds_set, ds_clr;

  assign wr_eff  = start ? req_wr : bus_write;
  assign in_t2   = (nxt.ph == PH_TW) || (nxt.ph == PH_T2);
  assign last_h1 = (nxt.ph == PH_T2) && nxt.hf && nxt.fin;
  assign hold_as = (nxt.ph == PH_T1 && nxt.hf) || (in_t2 && !last_h1);
  assign ds_set  = in_t2 && nxt.hf && !last_h1;
  assign ds_clr  = (nxt.ph == PH_IDLE) || last_h1;

  always_comb begin
    cs_d   = !(nxt.ph == PH_T1 && !nxt.hf);
    as_d   = !hold_as;
    oe_d   = wr_eff && (nxt.ph != PH_IDLE);
    done_d = last_h1;
    if (!wr_eff)     ds_d = !hold_as;
    else if (ds_set) ds_d = 1'b0;
    else if (ds_clr) ds_d = 1'b1;
    else             ds_d = data_stb_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ready    <= 1'b1;
      done         <= 1'b0;
      cyc_start_n  <= 1'b1;
      addr_stb_n   <= 1'b1;
      data_stb_n   <= 1'b1;
      bus_wdata_oe <= 1'b0;
    end else begin
      req_ready    <= (nxt.ph == PH_IDLE);
      done         <= done_d;
      cyc_start_n  <= cs_d;
      addr_stb_n   <= as_d;
      data_stb_n   <= ds_d;
      bus_wdata_oe <= oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      bus_stat  <= '0;
      bus_write <= 1'b0;
      bus_wdata <= '0;
    end else if (start) begin
      bus_addr  <= req_addr;
      bus_stat  <= req_stat;
      bus_write <= req_wr;
      bus_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       done_rdata <= '0;
    else if (last_h1 && !bus_write)   done_rdata <= bus_rdata;
  end

  // R1: idle means every strobe inactive and the data bus released
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cyc_start_n && addr_stb_n && data_stb_n && !bus_wdata_oe && !done));

  // R3: cycle-start lasts one clock and hands over to the address strobe
  assert_cs_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start_n |=> (cyc_start_n && !addr_stb_n));

  // R3: address held while the address strobe stays low
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_stb_n && $past(!addr_stb_n)) |-> $stable(bus_addr));

  // R4: done comes with both strobes released
  assert_done_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (addr_stb_n && data_stb_n && $past(!addr_stb_n)));

  // R9: a write data strobe never appears before a full bus state of address strobe
  assert_wr_ds_late_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(data_stb_n) && bus_write) |-> $past(!addr_stb_n, 2));
endmodule

// File: rtl/bus_master_seq.sv
module bus_master_seq
  import bmc_pkg::*;
#(
  parameter int AW        = 24,
  parameter int DW        = 32,
  parameter int SW        = 3,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_waits,
  input  logic          cfg_async,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wr,
  input  logic [SW-1:0] req_stat,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] done_rdata,
  output logic          cyc_start_n,
  output logic          addr_stb_n,
  output logic          data_stb_n,
  output logic [AW-1:0] bus_addr,
  output logic [SW-1:0] bus_stat,
  output logic          bus_write,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wdata_oe,
  input  logic [DW-1:0] bus_rdata,
  input  logic          ack_n
);
  localparam int WCW = 2;

  logic  start, ack_sync;
  slot_t nxt;

  assign start = req_valid && req_ready;

  bmc_ack_cond #(.STAGES(SYNC_STGS)) u_ack (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .ack_sync(ack_sync)
  );

  bmc_seq #(.WCW(WCW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_waits(cfg_waits),
    .cfg_async(cfg_async), .ack_raw_n(ack_n), .ack_sync(ack_sync), .nxt(nxt)
  );

  bmc_out #(.AW(AW), .DW(DW), .SW(SW)) u_out (
    .clk(clk), .rst_n(rst_n), .nxt(nxt), .start(start),
    .req_addr(req_addr), .req_wr(req_wr), .req_stat(req_stat), .req_wdata(req_wdata),
    .bus_rdata(bus_rdata), .req_ready(req_ready), .done(done), .done_rdata(done_rdata),
    .cyc_start_n(cyc_start_n), .addr_stb_n(addr_stb_n), .data_stb_n(data_stb_n),
    .bus_addr(bus_addr), .bus_stat(bus_stat), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe)
  );

  // R2: acceptance drops ready and starts the cycle on the next clock
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!req_ready && !cyc_start_n));
endmodule

// File: tb/sim_bus_master_seq.sv
`timescale 1ns/1ps
module sim_bus_master_seq;
  localparam int AW = 24, DW = 32, SW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_waits = '0;
  logic cfg_async = 1'b0, req_valid = 1'b0, req_wr = 1'b0, ack_n = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_stat = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, done, cyc_start_n, addr_stb_n, data_stb_n, bus_write, bus_wdata_oe;
  logic [DW-1:0] done_rdata, bus_wdata, bus_rdata;
  logic [AW-1:0] bus_addr;
  logic [SW-1:0] bus_stat;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return {8'hC3, a} ^ 32'h0F0F_5A5A;
  endfunction
  assign bus_rdata = mem_val(bus_addr);

  bus_master_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_waits(cfg_waits), .cfg_async(cfg_async),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_wr(req_wr),
    .req_stat(req_stat), .req_wdata(req_wdata), .done(done), .done_rdata(done_rdata),
    .cyc_start_n(cyc_start_n), .addr_stb_n(addr_stb_n), .data_stb_n(data_stb_n),
    .bus_addr(bus_addr), .bus_stat(bus_stat), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .bus_rdata(bus_rdata), .ack_n(ack_n)
  );

  int n_chk = 0, n_err = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [AW-1:0] addr; logic wr; logic [SW-1:0] st; logic [DW-1:0] wd;
    int len, as_c, ds_c, oe_c; logic [DW-1:0] rd;
  } exp_t;
  exp_t sb[$];

  // acknowledge responder: ack low from resp_a clocks after cycle start
  int resp_a = 0, rcnt = 0;
  bit rbusy = 0;
  always @(negedge clk) begin
    if (!rbusy && rst_n && !cyc_start_n) begin rbusy = 1; rcnt = 0; end
    else if (rbusy) rcnt++;
    if (rbusy && done) begin rbusy = 0; ack_n = 1'b1; end
    else ack_n = !(rbusy && rcnt >= resp_a);
  end

  // monitor: measures each cycle and compares against the scoreboard
  bit mbusy = 0, moved = 0;
  int k = 0, cs_c = 0, as_c = 0, ds_c = 0, oe_c = 0;
  logic [AW-1:0] a0; logic [SW-1:0] s0; logic w0; logic [DW-1:0] d0;
  always @(negedge clk) begin
    if (!mbusy && rst_n && !cyc_start_n) begin
      mbusy = 1; k = 0; cs_c = 0; as_c = 0; ds_c = 0; oe_c = 0; moved = 0;
      a0 = bus_addr; s0 = bus_stat; w0 = bus_write; d0 = bus_wdata;
    end
    if (mbusy) begin
      cs_c += int'(!cyc_start_n); as_c += int'(!addr_stb_n);
      ds_c += int'(!data_stb_n);  oe_c += int'(bus_wdata_oe);
      if (bus_addr != a0 || bus_stat != s0 || bus_write != w0 || bus_wdata != d0) moved = 1;
      if (done) begin
        exp_t e;
        mbusy = 0;
        if (sb.size() == 0) chk(0, "R2 unexpected done", 1, 0);
        else begin
          e = sb.pop_front();
          chk(k == e.len, "R5/R6/R7 done time", k, e.len);
          chk(cs_c == 1, "R3 cycle-start width", cs_c, 1);
          chk(a0 == e.addr && s0 == e.st && w0 == e.wr && (!e.wr || d0 == e.wd) && !moved,
              "R3 bus fields", a0, e.addr);
          chk(as_c == e.as_c, "R4 address strobe clocks", as_c, e.as_c);
          chk(ds_c == e.ds_c, e.wr ? "R9 write data strobe clocks" : "R8 read data strobe clocks",
              ds_c, e.ds_c);
          chk(oe_c == e.oe_c, "R11 write enable clocks", oe_c, e.oe_c);
          if (!e.wr) chk(done_rdata == e.rd, "R10 read data", done_rdata, e.rd);
        end
      end else k++;
    end
  end

  task automatic xfer(input logic [AW-1:0] a, input logic w, input logic [SW-1:0] s,
                      input logic [DW-1:0] d, input int nw, input logic asy, input int ad);
    exp_t e;
    int n, j;
    n = ad + (asy ? 2 : 0) - 2 - 2 * nw;
    j = (n <= 0) ? 0 : (n + 1) / 2;
    e.addr = a; e.wr = w; e.st = s; e.wd = d;
    e.len  = 3 + 2 * nw + 2 * j;
    e.as_c = 2 + 2 * nw + 2 * j;
    e.ds_c = !w ? e.as_c : ((nw + j + 1 > 1) ? 2 * nw + 2 * j : 0);
    e.oe_c = w ? e.len + 1 : 0;
    e.rd   = mem_val(a);
    @(negedge clk);
    cfg_waits = 2'(nw); cfg_async = asy; resp_a = ad;
    req_addr = a; req_wr = w; req_stat = s; req_wdata = d; req_valid = 1'b1;
    sb.push_back(e);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && !cyc_start_n, "R2 accept then start", {req_ready, cyc_start_n}, 0);
    cfg_waits = 2'(3 - nw); cfg_async = !asy;   // config change after accept must not matter
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(req_ready && addr_stb_n && data_stb_n && !bus_wdata_oe && !done, "R1 back to idle",
        {req_ready, addr_stb_n, data_stb_n, bus_wdata_oe, done}, 5'b11100);
  endtask

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 20000) begin
      chk(0, "watchdog expired", wd_cnt, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && cyc_start_n && addr_stb_n && data_stb_n && !bus_wdata_oe && !done,
        "R1 reset state", {req_ready, cyc_start_n, addr_stb_n, data_stb_n, bus_wdata_oe, done},
        6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    // synchronous reads, every wait count, immediate acknowledge
    for (int w = 0; w < 4; w++) xfer(24'h100 + 24'(w), 1'b0, 3'd5, '0, w, 1'b0, 0);
    // R6: ack present throughout waits is ignored until T2
    xfer(24'hABCDE, 1'b0, 3'd2, '0, 3, 1'b0, 0);
    // R6: late ack in sync mode adds T2 states
    xfer(24'h2222, 1'b0, 3'd1, '0, 1, 1'b0, 7);
    // R9: zero-wait write without strobe, then extended writes with strobe
    xfer(24'h3000, 1'b1, 3'd6, 32'hDEAD_BEEF, 0, 1'b0, 0);
    xfer(24'h3004, 1'b1, 3'd6, 32'h1234_5678, 0, 1'b0, 4);
    xfer(24'h3008, 1'b1, 3'd7, 32'hCAFE_F00D, 2, 1'b0, 0);
    // R7: asynchronous mode
    xfer(24'h4000, 1'b0, 3'd3, '0, 0, 1'b1, 0);
    xfer(24'h4010, 1'b0, 3'd3, '0, 2, 1'b1, 3);   // ack during last wait
    xfer(24'h4020, 1'b0, 3'd3, '0, 1, 1'b1, 4);   // ack too late, one extra T2
    xfer(24'h4030, 1'b1, 3'd4, 32'h0BAD_F00D, 0, 1'b1, 0);
    xfer(24'h4040, 1'b1, 3'd4, 32'h5555_AAAA, 3, 1'b1, 5);
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R2 all requests completed", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule